// File: doc/BRIEF.md
# Critical-Word-First Line Fill Unit

This unit services one cache read miss at a time. The miss arrives as a physical line address plus the index of the 64-bit chunk that holds the demanded doubleword. The physical address is already translated by then. The unit records both in a single miss-tracking entry. It then asks the next memory level for the whole 64-byte line, naming the demanded chunk as the start of the burst. The memory side returns eight 64-bit beats. They begin at that chunk and wrap around the end of the line.

Each arriving beat goes straight into the line storage at the chunk position it belongs to. The first beat is the demanded chunk. In the same cycle it is written, it is also presented on the load-return port, so the stalled pipeline can restart without a second lookup while the rest of the line streams in behind it.

Only when all eight chunks are stored does the unit announce the line as valid, together with its tag. Until then the line counts as absent. The unit takes no new miss while a fill is active.

The controller steps through four named states:
- FS_IDLE: waiting for a miss. This is the only state in which a miss is accepted.
- FS_REQ: the burst request is held until memory takes it.
- FS_FILL: beats are collected.
- FS_DONE: a one-cycle state in which the line is published.

The transitions are:
- IDLE→REQ, on an accepted miss.
- REQ→FILL, on request handshake.
- FILL→DONE, on the eighth beat.
- DONE→IDLE, unconditionally.

Top module: `line_fill_unit`

## Requirements
- R1: While reset is held and right after it, miss_ready is 1 and mreq_valid, mbeat_ready, wr_en, ld_ret_valid and line_valid are 0.
- R2: The cycle after a miss is accepted (miss_valid and miss_ready both 1), mreq_valid is 1 with mreq_line equal to the accepted miss_line and mreq_start_beat equal to the accepted miss_beat. These three outputs hold unchanged until mreq_ready is seen, and mreq_valid is 0 in the cycle after.
- R3: The k-th beat accepted (k = 0..7, mbeat_valid and mbeat_ready both 1) produces wr_en = 1 in that same cycle. In that cycle wr_idx = (start + k) mod 8 and wr_data = mbeat_data.
- R4: ld_ret_valid is 1 only in the cycle of the first accepted beat of a fill. In that cycle ld_ret_data equals mbeat_data.
- R5: Cycles in the fill phase with mbeat_valid = 0 produce wr_en = 0 and ld_ret_valid = 0, and the beat position does not advance.
- R6: line_valid is 1 for exactly one cycle, the cycle after the eighth beat, with line_tag equal to the accepted line address. It is 0 at all other times.
- R7: miss_ready is 0 from the cycle after a miss is accepted through the line_valid cycle. A miss offered in that window is ignored and does not alter the line being filled.
- R8: mbeat_ready is 1 exactly during the fill phase: after the request handshake and until the eighth beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A read miss is offered |
| miss_ready | output | 1 | Unit is idle and accepts a miss |
| miss_line | input | LINE_W (34) | Physical line address of the miss |
| miss_beat | input | IDX_W (3) | Index of the chunk holding the demanded doubleword |
| mreq_valid | output | 1 | Burst request to next level is pending |
| mreq_ready | input | 1 | Next level takes the request |
| mreq_line | output | LINE_W (34) | Line address of the request |
| mreq_start_beat | output | IDX_W (3) | Chunk the wrapping burst starts at |
| mbeat_valid | input | 1 | A data beat is presented |
| mbeat_ready | output | 1 | Unit accepts a beat |
| mbeat_data | input | DATA_W (64) | Beat payload |
| ld_ret_valid | output | 1 | Demanded chunk returned to the pipeline |
| ld_ret_data | output | DATA_W (64) | Returned doubleword |
| wr_en | output | 1 | Line storage write strobe |
| wr_idx | output | IDX_W (3) | Chunk position within the line |
| wr_data | output | DATA_W (64) | Data written to the line storage |
| line_valid | output | 1 | Line complete; tag and valid may be written |
| line_tag | output | LINE_W (34) | Line address of the completed line |

## Verification
The bench builds the unit with its defaults: 40-bit physical addresses, 64-bit beats and eight beats per line. This keeps the chunk index three bits wide, so a start at chunk 7 wraps after the very first beat and a start at chunk 0 does not wrap at all. Both corners are driven along with a mid-line start. The runs insert idle cycles between beats and delay the request handshake. They also offer a competing miss during a fill, so the line tag shows whether it was wrongly taken.

// File: rtl/lfu_pkg.sv
package lfu_pkg;
    typedef enum logic [1:0] {
        FS_IDLE,
        FS_REQ,
        FS_FILL,
        FS_DONE
    } fill_state_e;
endpackage

// File: rtl/lfu_miss_entry.sv
// Single miss-tracking entry: physical line address and demanded chunk.
module lfu_miss_entry #(
    parameter int LINE_W = 34,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LINE_W-1:0] line_in,
    input  logic [IDX_W-1:0]  beat_in,
    output logic [LINE_W-1:0] line_q,
    output logic [IDX_W-1:0]  beat_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            beat_q <= '0;
        end else if (load) begin
            line_q <= line_in;
            beat_q <= beat_in;
        end
    end
endmodule

// File: rtl/lfu_beat_seq.sv
// Counts accepted beats and maps beat k to chunk (start + k) mod BEATS.
module lfu_beat_seq #(
    parameter int BEATS = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [IDX_W-1:0] start,
    output logic [IDX_W-1:0] idx,
    output logic             first,
    output logic             last
);
    localparam logic [IDX_W:0]   NBEATS   = (IDX_W+1)'(BEATS);
    localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(BEATS - 1);

    logic [IDX_W-1:0] cnt;
    logic [IDX_W:0]   sum;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        sum = {1'b0, start} + {1'b0, cnt};
        if (sum >= NBEATS) begin
            sum = sum - NBEATS;
        end
        idx   = sum[IDX_W-1:0];
        first = (cnt == '0);
        last  = (cnt == LAST_CNT);
    end
endmodule

// File: rtl/lfu_fill_ctrl.sv
// Fill controller: idle -> request -> fill -> done.
module lfu_fill_ctrl
    import lfu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss_valid,
    input  logic mreq_ready,
    input  logic mbeat_valid,
    input  logic last_beat,
    output logic miss_ready,
    output logic entry_load,
    output logic mreq_valid,
    output logic mbeat_ready,
    output logic beat_take,
    output logic fill_done
);
    fill_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: if (miss_valid)              state_d = FS_REQ;
            FS_REQ:  if (mreq_ready)              state_d = FS_FILL;
            FS_FILL: if (mbeat_valid && last_beat) state_d = FS_DONE;
            FS_DONE:                              state_d = FS_IDLE;
            default:                              state_d = FS_IDLE;
        endcase
    end

    always_comb begin
        miss_ready  = 1'b0;
        mreq_valid  = 1'b0;
        mbeat_ready = 1'b0;
        fill_done   = 1'b0;
        unique case (state_q)
            FS_IDLE: miss_ready  = 1'b1;
            FS_REQ:  mreq_valid  = 1'b1;
            FS_FILL: mbeat_ready = 1'b1;
            FS_DONE: fill_done   = 1'b1;
            default: ;
        endcase
        entry_load = miss_ready && miss_valid;
        beat_take  = mbeat_ready && mbeat_valid;
    end
endmodule

// File: rtl/line_fill_unit.sv
// Critical-word-first line fill: wrapping burst, first beat forwarded.
module line_fill_unit #(
    parameter int ADDR_W = 40,
    parameter int DATA_W = 64,
    parameter int BEATS  = 8
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             miss_valid,
    output logic                                             miss_ready,
    input  logic [ADDR_W-$clog2(BEATS*DATA_W/8)-1:0]         miss_line,
    input  logic [$clog2(BEATS)-1:0]                         miss_beat,
    output logic                                             mreq_valid,
    input  logic                                             mreq_ready,
    output logic [ADDR_W-$clog2(BEATS*DATA_W/8)-1:0]         mreq_line,
    output logic [$clog2(BEATS)-1:0]                         mreq_start_beat,
    input  logic                                             mbeat_valid,
    output logic                                             mbeat_ready,
    input  logic [DATA_W-1:0]                                mbeat_data,
    output logic                                             ld_ret_valid,
    output logic [DATA_W-1:0]                                ld_ret_data,
    output logic                                             wr_en,
    output logic [$clog2(BEATS)-1:0]                         wr_idx,
    output logic [DATA_W-1:0]                                wr_data,
    output logic                                             line_valid,
    output logic [ADDR_W-$clog2(BEATS*DATA_W/8)-1:0]         line_tag
);
    localparam int LINE_BYTES = BEATS * DATA_W / 8;
    localparam int IDX_W      = $clog2(BEATS);
    localparam int LINE_W     = ADDR_W - $clog2(LINE_BYTES);

    logic              entry_load;
    logic              beat_take;
    logic              first_beat;
    logic              last_beat;
    logic              fill_done;
    logic [LINE_W-1:0] ent_line;
    logic [IDX_W-1:0]  ent_beat;
    logic [IDX_W-1:0]  chunk_idx;

    lfu_miss_entry #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_entry (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (entry_load),
        .line_in (miss_line),
        .beat_in (miss_beat),
        .line_q  (ent_line),
        .beat_q  (ent_beat)
    );

    lfu_beat_seq #(.BEATS(BEATS), .IDX_W(IDX_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (entry_load),
        .step  (beat_take),
        .start (ent_beat),
        .idx   (chunk_idx),
        .first (first_beat),
        .last  (last_beat)
    );

    lfu_fill_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_valid  (miss_valid),
        .mreq_ready  (mreq_ready),
        .mbeat_valid (mbeat_valid),
        .last_beat   (last_beat),
        .miss_ready  (miss_ready),
        .entry_load  (entry_load),
        .mreq_valid  (mreq_valid),
        .mbeat_ready (mbeat_ready),
        .beat_take   (beat_take),
        .fill_done   (fill_done)
    );

    always_comb begin
        mreq_line       = ent_line;
        mreq_start_beat = ent_beat;
        wr_en           = beat_take;
        wr_idx          = chunk_idx;
        wr_data         = mbeat_data;
        ld_ret_valid    = beat_take && first_beat;
        ld_ret_data     = mbeat_data;
        line_valid      = fill_done;
        line_tag        = ent_line;
    end
endmodule

// File: rtl/lfu_checker.sv
// Temporal checks for line_fill_unit, attached by bind.
module lfu_checker #(
    parameter int BEATS = 8,
    parameter int IDX_W = 3,
    parameter int LINE_W = 34
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic              mreq_valid,
    input logic              mreq_ready,
    input logic [LINE_W-1:0] mreq_line,
    input logic [IDX_W-1:0]  mreq_start_beat,
    input logic              mbeat_ready,
    input logic              ld_ret_valid,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              line_valid
);
    localparam logic [IDX_W:0] NBEATS = (IDX_W+1)'(BEATS);

    logic [IDX_W:0] wcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (miss_valid && miss_ready) begin
            wcnt <= '0;
        end else if (wr_en) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_line) && $stable(mreq_start_beat)));

    assert_no_extra_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wcnt < NBEATS));

    assert_fwd_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ret_valid |-> (wr_en && wcnt == '0 && wr_idx == mreq_start_beat));

    assert_full_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (wcnt == NBEATS));

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |=> !line_valid);

    assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid || mbeat_ready || line_valid) |-> !miss_ready);

    assert_beat_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mbeat_ready |-> (!mreq_valid && !line_valid));
endmodule

bind line_fill_unit lfu_checker #(
    .BEATS  (BEATS),
    .IDX_W  (IDX_W),
    .LINE_W (LINE_W)
) u_lfu_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .miss_valid      (miss_valid),
    .miss_ready      (miss_ready),
    .mreq_valid      (mreq_valid),
    .mreq_ready      (mreq_ready),
    .mreq_line       (mreq_line),
    .mreq_start_beat (mreq_start_beat),
    .mbeat_ready     (mbeat_ready),
    .ld_ret_valid    (ld_ret_valid),
    .wr_en           (wr_en),
    .wr_idx          (wr_idx),
    .line_valid      (line_valid)
);

// File: tb/tb_line_fill_unit.sv
module tb_line_fill_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 34;
    localparam int IW = 3;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic          miss_ready;
    logic [LW-1:0] miss_line = '0;
    logic [IW-1:0] miss_beat = '0;
    logic          mreq_valid;
    logic          mreq_ready = 1'b0;
    logic [LW-1:0] mreq_line;
    logic [IW-1:0] mreq_start_beat;
    logic          mbeat_valid = 1'b0;
    logic          mbeat_ready;
    logic [DW-1:0] mbeat_data = '0;
    logic          ld_ret_valid;
    logic [DW-1:0] ld_ret_data;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [DW-1:0] wr_data;
    logic          line_valid;
    logic [LW-1:0] line_tag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_fill_unit dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_line(miss_line), .miss_beat(miss_beat),
        .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
        .mreq_line(mreq_line), .mreq_start_beat(mreq_start_beat),
        .mbeat_valid(mbeat_valid), .mbeat_ready(mbeat_ready), .mbeat_data(mbeat_data),
        .ld_ret_valid(ld_ret_valid), .ld_ret_data(ld_ret_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .line_valid(line_valid), .line_tag(line_tag)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input logic [LW-1:0] ln, input int chunk);
        return 64'hC0DE_0000_0000_0000 ^ (64'(ln) << 8) ^ 64'(chunk);
    endfunction

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "miss_ready in reset", 64'(miss_ready), 64'd1);
        chk("R1", "mreq_valid in reset", 64'(mreq_valid), 64'd0);
        chk("R1", "mbeat_ready in reset", 64'(mbeat_ready), 64'd0);
        chk("R1", "line_valid in reset", 64'(line_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "miss_ready after reset", 64'(miss_ready), 64'd1);
        chk("R1", "wr_en after reset", 64'(wr_en), 64'd0);
        chk("R1", "ld_ret_valid after reset", 64'(ld_ret_valid), 64'd0);
    endtask

    // One complete miss: gaps[k] inserts an idle cycle before beat k,
    // poke offers a competing miss during the fill.
    task automatic run_fill(input logic [LW-1:0] ln, input int sb,
                            input logic [7:0] gaps, input int req_wait, input bit poke);
        @(negedge clk);
        miss_line  = ln;
        miss_beat  = IW'(sb);
        miss_valid = 1'b1;
        #1;
        chk("R7", "miss_ready when idle", 64'(miss_ready), 64'd1);
        @(negedge clk);
        miss_valid = 1'b0;
        #1;
        chk("R2", "mreq_valid after accept", 64'(mreq_valid), 64'd1);
        chk("R2", "mreq_line", 64'(mreq_line), 64'(ln));
        chk("R2", "mreq_start_beat", 64'(mreq_start_beat), 64'(sb));
        chk("R7", "miss_ready while requesting", 64'(miss_ready), 64'd0);
        for (int w = 0; w < req_wait; w++) begin
            @(negedge clk);
            #1;
            chk("R2", "mreq_valid held", 64'(mreq_valid), 64'd1);
            chk("R2", "mreq_start_beat held", 64'(mreq_start_beat), 64'(sb));
            chk("R8", "mbeat_ready before handshake", 64'(mbeat_ready), 64'd0);
        end
        mreq_ready = 1'b1;
        @(negedge clk);
        mreq_ready = 1'b0;
        #1;
        chk("R2", "mreq_valid after handshake", 64'(mreq_valid), 64'd0);
        for (int k = 0; k < 8; k++) begin
            if (gaps[k]) begin
                mbeat_valid = 1'b0;
                if (poke) begin
                    miss_valid = 1'b1;
                    miss_line  = ~ln;
                    miss_beat  = IW'(sb + 1);
                end
                #1;
                chk("R5", "wr_en on idle cycle", 64'(wr_en), 64'd0);
                chk("R5", "ld_ret_valid on idle cycle", 64'(ld_ret_valid), 64'd0);
                chk("R7", "miss_ready during fill", 64'(miss_ready), 64'd0);
                @(negedge clk);
            end
            mbeat_valid = 1'b1;
            mbeat_data  = pat(ln, (sb + k) % 8);
            #1;
            chk("R8", "mbeat_ready in fill", 64'(mbeat_ready), 64'd1);
            chk("R3", "wr_en on beat", 64'(wr_en), 64'd1);
            chk("R3", "wr_idx wraps", 64'(wr_idx), 64'((sb + k) % 8));
            chk("R3", "wr_data", wr_data, pat(ln, (sb + k) % 8));
            chk("R4", "ld_ret_valid only first beat", 64'(ld_ret_valid), 64'(k == 0));
            if (k == 0) chk("R4", "ld_ret_data", ld_ret_data, pat(ln, sb));
            chk("R6", "line_valid early", 64'(line_valid), 64'd0);
            @(negedge clk);
        end
        mbeat_valid = 1'b0;
        miss_valid  = 1'b0;
        #1;
        chk("R6", "line_valid after last beat", 64'(line_valid), 64'd1);
        chk("R6", "line_tag", 64'(line_tag), 64'(ln));
        chk("R8", "mbeat_ready after last beat", 64'(mbeat_ready), 64'd0);
        chk("R7", "miss_ready in done cycle", 64'(miss_ready), 64'd0);
        @(negedge clk);
        #1;
        chk("R6", "line_valid single pulse", 64'(line_valid), 64'd0);
        chk("R7", "miss_ready back", 64'(miss_ready), 64'd1);
        chk("R7", "no stray request", 64'(mreq_valid), 64'd0);
    endtask

    initial begin
        test_reset();
        run_fill(34'h2_1234_5678, 5, 8'b0010_0110, 2, 1'b1);
        run_fill(34'h0_0000_0ABC, 0, 8'b0000_0000, 0, 1'b0);
        run_fill(34'h3_FFFF_FFFF, 7, 8'b1111_1111, 0, 1'b1);
        run_fill(34'h1_0F0F_0F0F, 3, 8'b1000_0001, 1, 1'b1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule